// File: doc/BRIEF.md
# Two-or-More Ones Detector (Cell Cascade and Serial Form)

This block decides whether at least two bits of a vector are set. It is built from one small cell that carries a three-valued tally to the next cell on two wires. The first wire means "exactly one set bit seen so far". The second wire means "two or more set bits seen". When neither wire is active, no set bit has been seen. Because every cell is identical, the description stays the same size whatever the vector width is.

The block uses this one cell in two ways. A parameterised chain of cells turns a parallel vector into a combinational flag, taken from the second wire of the rightmost cell. The same cell, closed around a two-bit register, forms a clocked serial detector. It takes one bit per clock while a strobe is high, so bits ordered in time stand in for bits ordered in space. The serial form presents its full two-wire tally as its running result.

Top module: `pair_detect`

## Requirements
- R1: `vec_hit` is high, combinationally within the same cycle, exactly when two or more bits of `vec_in` are 1; this holds for every value of `vec_in`.
- R2: The chain begins in the "none seen" tally. A vector with a single 1 at any position, including bit 0 and bit N-1, gives `vec_hit` low. A vector with 1s at only bit 0 and bit N-1 gives `vec_hit` high.
- R3: An all-zero `vec_in` gives `vec_hit` low, and an all-ones `vec_in` gives `vec_hit` high.
- R4: Reset is synchronous and active high. On the clock edge where `rst` is high, `ser_state` becomes 2'b00, whatever the serial tally held before.
- R5: The encoding of `ser_state` is: 2'b00 = no 1 accepted, 2'b01 = exactly one 1 accepted, 2'b10 = two or more accepted. An accepted 1 moves the tally from 2'b00 to 2'b01, and from 2'b01 to 2'b10. Each change is visible after the clock edge that accepts the bit.
- R6: While `bit_valid` is low, `ser_state` holds its value and `bit_in` has no effect.
- R7: Once `ser_state[1]` is high, it stays high for any further accepted bits until reset.
- R8: An accepted 0 (`bit_valid` high, `bit_in` low) leaves `ser_state` unchanged.
- R9: `ser_state` never has both bits high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the serial detector |
| rst | input | 1 | Synchronous active-high reset of the serial tally |
| vec_in | input | N | Parallel vector fed to the cell chain |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Strobe: `bit_in` is accepted on this clock edge |
| vec_hit | output | 1 | High when `vec_in` has two or more set bits |
| ser_state | output | 2 | Serial running tally: bit 0 = exactly one seen, bit 1 = two or more seen |

## Verification
The parallel result has no register in its path. The bench applies each vector, waits one nanosecond for the chain to settle, and samples `vec_hit` in the same cycle. The serial tally passes through one register. The bench drives `bit_in`, `bit_valid` and `rst` on a falling edge, lets the next rising edge take them, and compares `ser_state` at the following falling edge, exactly one edge after the stimulus. The serial reference is a saturating counter kept in the bench, and the parallel reference is a loop that counts set bits.

// File: rtl/pair_detect_pkg.sv
package pair_detect_pkg;

    // Two-wire tally passed from a cell to its right-hand neighbour.
    // Neither wire active: nothing seen; one_seen: exactly one; two_up: two or more.
    typedef struct packed {
        logic two_up;
        logic one_seen;
    } link_t;

    localparam link_t LINK_IDLE = '{two_up: 1'b0, one_seen: 1'b0};

    // The single cell function shared by the spatial and temporal forms.
    function automatic link_t cell_next(input link_t l, input logic b);
        link_t n;
        n.two_up   = l.two_up | (l.one_seen & b);
        n.one_seen = (l.one_seen & ~b) | (~l.one_seen & ~l.two_up & b);
        return n;
    endfunction

endpackage

// File: rtl/pair_cell.sv
module pair_cell
    import pair_detect_pkg::*;
(
    input  link_t link_in,
    input  logic  cell_bit,
    output link_t link_out
);
    assign link_out = cell_next(link_in, cell_bit);
endmodule

// File: rtl/pair_chain.sv
module pair_chain
    import pair_detect_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] bits,
    output link_t        tail
);
    link_t lnk [0:N];

    // Leftmost cell sees an idle tally.
    assign lnk[0] = LINK_IDLE;

    for (genvar i = 0; i < N; i++) begin : g_cell
        pair_cell cell_i (
            .link_in (lnk[i]),
            .cell_bit(bits[i]),
            .link_out(lnk[i+1])
        );
    end

    assign tail = lnk[N];
endmodule

// File: rtl/pair_serial.sv
module pair_serial
    import pair_detect_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  bit_in,
    input  logic  bit_valid,
    output link_t state_q
);
    link_t state_d;

    pair_cell cell_i (
        .link_in (state_q),
        .cell_bit(bit_in),
        .link_out(state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= LINK_IDLE;
        end else if (bit_valid) begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pair_detect.sv
module pair_detect
    import pair_detect_pkg::*;
#(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] vec_in,
    input  logic         bit_in,
    input  logic         bit_valid,
    output logic         vec_hit,
    output logic [1:0]   ser_state
);
    link_t chain_tail;
    link_t ser_q;

    pair_chain #(.N(N)) chain_i (
        .bits(vec_in),
        .tail(chain_tail)
    );

    pair_serial serial_i (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (bit_in),
        .bit_valid(bit_valid),
        .state_q  (ser_q)
    );

    assign vec_hit   = chain_tail.two_up;
    assign ser_state = ser_q;
endmodule

// File: rtl/pair_detect_chk.sv
module pair_detect_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] vec_in,
    input logic         bit_in,
    input logic         bit_valid,
    input logic         vec_hit,
    input logic [1:0]   ser_state
);
    assert_vec_threshold_R1: assert property (@(posedge clk) disable iff (rst)
        vec_hit == ($countones(vec_in) >= 2));

    assert_reset_clears_R4: assert property (@(posedge clk)
        rst |=> (ser_state == 2'b00));

    assert_first_one_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in && ser_state == 2'b00) |=> (ser_state == 2'b01));

    assert_second_one_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_in && ser_state == 2'b01) |=> (ser_state == 2'b10));

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |=> $stable(ser_state));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ser_state[1] |=> ser_state[1]);

    assert_zero_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_in) |=> $stable(ser_state));

    assert_lines_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ser_state));
endmodule

bind pair_detect pair_detect_chk #(.N(N)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .vec_in   (vec_in),
    .bit_in   (bit_in),
    .bit_valid(bit_valid),
    .vec_hit  (vec_hit),
    .ser_state(ser_state)
);

// File: tb/pair_detect_tb_top.sv
`timescale 1ns/1ps
module pair_detect_tb_top;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] vec_in = '0;
    logic         bit_in = 1'b0;
    logic         bit_valid = 1'b0;
    logic         vec_hit;
    logic [1:0]   ser_state;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    pair_detect #(.N(N)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .vec_in   (vec_in),
        .bit_in   (bit_in),
        .bit_valid(bit_valid),
        .vec_hit  (vec_hit),
        .ser_state(ser_state)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return c;
    endfunction

    function automatic logic [1:0] ref_state();
        if (ref_cnt == 0) return 2'b00;
        if (ref_cnt == 1) return 2'b01;
        return 2'b10;
    endfunction

    task automatic apply_vec(input logic [N-1:0] v, input string tag);
        vec_in = v;
        #1;
        check(tag, {31'd0, vec_hit}, {31'd0, ones(v) >= 2});
    endtask

    // Called on a falling edge; returns on the next falling edge.
    task automatic push(input logic b, input logic v, input string tag);
        bit_in = b;
        bit_valid = v;
        @(negedge clk);
        if (v && b && ref_cnt < 2) ref_cnt++;
        bit_valid = 1'b0;
        bit_in = 1'b0;
        check(tag, {30'd0, ser_state}, {30'd0, ref_state()});
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ref_cnt = 0;
        check(tag, {30'd0, ser_state}, 32'd0);
    endtask

    task automatic t_exhaustive();
        for (int v = 0; v < (1 << N); v++) apply_vec(v[N-1:0], "R1 exhaustive");
    endtask

    task automatic t_random();
        for (int k = 0; k < 300; k++) apply_vec(N'($urandom), "R1 random");
    endtask

    task automatic t_edges();
        apply_vec('0, "R3 all zero");
        apply_vec('1, "R3 all ones");
        for (int i = 0; i < N; i++) apply_vec(N'(1) << i, "R2 single one");
        apply_vec((N'(1) << (N-1)) | N'(1), "R2 outer pair");
    endtask

    task automatic t_serial_count();
        do_reset("R4 reset state");
        push(1'b1, 1'b1, "R5 first one");
        push(1'b1, 1'b1, "R5 second one");
        push(1'b1, 1'b1, "R7 stays high on one");
        push(1'b0, 1'b1, "R7 stays high on zero");
        do_reset("R4 reset after hit");
    endtask

    task automatic t_serial_zeros();
        do_reset("R4 reset");
        push(1'b0, 1'b1, "R8 zero in idle");
        push(1'b1, 1'b1, "R5 one after zero");
        push(1'b0, 1'b1, "R8 zero keeps one");
        push(1'b0, 1'b1, "R8 zero keeps one again");
        push(1'b1, 1'b1, "R5 reaches two");
        check("R9 lines exclusive", {31'd0, &ser_state}, 32'd0);
    endtask

    task automatic t_serial_hold();
        do_reset("R4 reset");
        push(1'b1, 1'b0, "R6 ignored one in idle");
        push(1'b1, 1'b0, "R6 ignored one again");
        push(1'b1, 1'b1, "R5 accepted one");
        push(1'b1, 1'b0, "R6 held at one");
        push(1'b1, 1'b1, "R5 accepted second");
    endtask

    task automatic t_serial_random();
        do_reset("R4 reset");
        for (int k = 0; k < 200; k++) begin
            if (k % 37 == 36) do_reset("R4 periodic reset");
            else push(1'($urandom), 1'($urandom), "R5 random stream");
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R4 state after reset", {30'd0, ser_state}, 32'd0);
        t_edges();
        t_exhaustive();
        t_random();
        t_serial_count();
        t_serial_zeros();
        t_serial_hold();
        t_serial_random();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule